// File: doc/BRIEF.md
# MDIO Management Target

This block is the PHY-side end of the two-wire serial management link. It watches the management clock (MDC) and the shared data line (MDIO) and turns each serial frame into one access on a register-file port. It oversamples both lines with the system clock and acts on MDC edges. Each frame is decoded field by field: preamble, start, opcode, PHY address, register address, turnaround and 16 data bits. A read then drives the register's contents back onto the line, and a write gives the register bank one strobe.

The line is driven through a tri-state pad: `mdio_oe` enables the pad and `mdio_out` is the bit driven. The block samples a strap value for its own PHY address while reset is asserted and keeps it from then on. The register bank is outside the block. It answers a combinational read and tells, through `reg_hit`, whether the currently addressed register exists.

Top module: `mdio_target`

## Requirements
- R1: The PHY address is taken from `phy_addr_strap` on every clock edge while `rst` is high and is held unchanged after reset ends; later strap changes do not change which frames are answered.
- R2: A frame is recognised only after at least 32 consecutive ones sampled on MDC rising edges, followed by a zero and then a one; with only 31 leading ones the frame is ignored.
- R3: The opcode is the two bits after the start pattern, first bit first: 10 is a read, 01 is a write; 00 and 11 cause no line drive and no write strobe.
- R4: A frame whose 5-bit PHY address field (MSB first) differs from the captured address causes no line drive and no write strobe.
- R5: In a read, `mdio_oe` stays low through the first turnaround bit, then goes high with `mdio_out` low for the second turnaround bit.
- R6: In a read, the 16 data bits are driven MSB first, each one updated after an MDC falling edge, and the line is released at the falling edge after the last data bit.
- R7: A read of a register for which `reg_hit` is low returns 16'hFFFF.
- R8: A write whose turnaround is 1 then 0 produces exactly one single-cycle `reg_we` pulse after the 16th data bit, with `reg_addr` holding the 5-bit register address (MSB first) and `reg_wdata` holding the data received MSB first.
- R9: A write to a register for which `reg_hit` is low produces no `reg_we` pulse.
- R10: A new frame is accepted directly after the last data bit of the previous one, with no idle bit in between.
- R11: `mdio_oe` is low after reset, throughout write frames and whenever no read turnaround or read data bit is being driven.
- R12: A write whose turnaround bits are not 1 then 0 is abandoned without a `reg_we` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample MDC and MDIO |
| rst | input | 1 | Synchronous active-high reset; also the PHY address capture window |
| mdc | input | 1 | Management clock from the station |
| mdio_in | input | 1 | Data line as seen at the pad |
| mdio_oe | output | 1 | Pad output enable |
| mdio_out | output | 1 | Bit driven onto the pad when enabled |
| phy_addr_strap | input | 5 | Strap value for this PHY's address |
| reg_addr | output | 5 | Register address of the current frame |
| reg_wdata | output | 16 | Write data, valid with `reg_we` |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_rdata | input | 16 | Contents of the addressed register |
| reg_hit | input | 1 | High when the addressed register exists |

## Verification
A wrong frame state is exposed within the same frame. A slip in the field counters moves the register address or data by a bit, so a write lands in the wrong register or with shifted data, and reading it back shows the error on the next frame. A broken preamble counter or address compare shows up at once as a frame that is answered when it should be ignored, or ignored when it should be answered. A wrong state in the read driver shows on the line within one bit time: an early or late enable in turnaround, or a data word reversed or offset. Strobe faults show as a missing or doubled write, and counting strobes per frame catches them.

// File: rtl/mdio_target_pkg.sv
package mdio_target_pkg;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_OP,
        ST_PHY,
        ST_REG,
        ST_TA1,
        ST_TA2,
        ST_DATA
    } mdio_state_e;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_READ,
        ACC_WRITE
    } mdio_access_e;

    localparam logic [1:0] OPC_READ  = 2'b10;
    localparam logic [1:0] OPC_WRITE = 2'b01;

    typedef struct packed {
        logic rise;
        logic fall;
        logic bit_val;
    } mdc_evt_t;

    function automatic mdio_access_e decode_op(input logic [1:0] op);
        case (op)
            OPC_READ:  return ACC_READ;
            OPC_WRITE: return ACC_WRITE;
            default:   return ACC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/mdio_edge_sync.sv
module mdio_edge_sync
    import mdio_target_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     mdc,
    input  logic     mdio_in,
    output mdc_evt_t evt
);
    localparam int CLK_TAPS = SYNC_STAGES + 1;

    logic [CLK_TAPS-1:0]    clk_sh;
    logic [SYNC_STAGES-1:0] dat_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_sh <= '1;
            dat_sh <= '1;
        end else begin
            clk_sh[0] <= mdc;
            for (int i = 1; i < CLK_TAPS; i++) clk_sh[i] <= clk_sh[i-1];
            dat_sh[0] <= mdio_in;
            for (int i = 1; i < SYNC_STAGES; i++) dat_sh[i] <= dat_sh[i-1];
        end
    end

    always_comb begin
        evt.rise    = clk_sh[SYNC_STAGES-1] & ~clk_sh[SYNC_STAGES];
        evt.fall    = ~clk_sh[SYNC_STAGES-1] & clk_sh[SYNC_STAGES];
        evt.bit_val = dat_sh[SYNC_STAGES-1];
    end
endmodule

// File: rtl/mdio_frame_fsm.sv
module mdio_frame_fsm
    import mdio_target_pkg::*;
#(
    parameter int PHY_AW  = 5,
    parameter int REG_AW  = 5,
    parameter int DATA_W  = 16,
    parameter int PRE_MIN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_rise,
    input  logic              bit_val,
    input  logic [PHY_AW-1:0] own_addr,
    input  logic              reg_hit,
    output mdio_state_e       state,
    output logic              is_read,
    output logic [REG_AW-1:0] reg_addr,
    output logic              reg_we,
    output logic [DATA_W-1:0] reg_wdata
);
    localparam int CNT_W = $clog2(PRE_MIN + 1);
    localparam int BIT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] PRE_FULL = CNT_W'(PRE_MIN);

    logic [CNT_W-1:0]  ones_cnt;
    logic [BIT_W-1:0]  bit_cnt;
    logic              op_first;
    logic [PHY_AW-1:0] phy_sh;
    logic [DATA_W-1:0] wr_sh;
    mdio_access_e      acc;

    assign acc = decode_op({op_first, bit_val});

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_HUNT;
            ones_cnt  <= '0;
            bit_cnt   <= '0;
            op_first  <= 1'b0;
            is_read   <= 1'b0;
            phy_sh    <= '0;
            reg_addr  <= '0;
            wr_sh     <= '0;
            reg_we    <= 1'b0;
            reg_wdata <= '0;
        end else begin
            reg_we <= 1'b0;
            if (bit_rise) begin
                case (state)
                    ST_HUNT: begin
                        if (bit_val) begin
                            if (ones_cnt != PRE_FULL) ones_cnt <= ones_cnt + 1'b1;
                        end else begin
                            if (ones_cnt == PRE_FULL) state <= ST_START;
                            ones_cnt <= '0;
                        end
                    end
                    ST_START: begin
                        bit_cnt <= '0;
                        state   <= bit_val ? ST_OP : ST_HUNT;
                    end
                    ST_OP: begin
                        op_first <= bit_val;
                        if (bit_cnt == BIT_W'(1)) begin
                            bit_cnt <= '0;
                            is_read <= (acc == ACC_READ);
                            state   <= (acc == ACC_NONE) ? ST_HUNT : ST_PHY;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_PHY: begin
                        phy_sh <= {phy_sh[PHY_AW-2:0], bit_val};
                        if (bit_cnt == BIT_W'(PHY_AW - 1)) begin
                            bit_cnt <= '0;
                            state   <= ({phy_sh[PHY_AW-2:0], bit_val} == own_addr)
                                       ? ST_REG : ST_HUNT;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_REG: begin
                        reg_addr <= {reg_addr[REG_AW-2:0], bit_val};
                        if (bit_cnt == BIT_W'(REG_AW - 1)) begin
                            bit_cnt <= '0;
                            state   <= ST_TA1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    ST_TA1: begin
                        state <= (!is_read && !bit_val) ? ST_HUNT : ST_TA2;
                    end
                    ST_TA2: begin
                        bit_cnt <= '0;
                        state   <= (!is_read && bit_val) ? ST_HUNT : ST_DATA;
                    end
                    ST_DATA: begin
                        wr_sh <= {wr_sh[DATA_W-2:0], bit_val};
                        if (bit_cnt == BIT_W'(DATA_W - 1)) begin
                            bit_cnt <= '0;
                            state   <= ST_HUNT;
                            if (!is_read && reg_hit) begin
                                reg_we    <= 1'b1;
                                reg_wdata <= {wr_sh[DATA_W-2:0], bit_val};
                            end
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: state <= ST_HUNT;
                endcase
            end
        end
    end
endmodule

// File: rtl/mdio_read_driver.sv
module mdio_read_driver
    import mdio_target_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_rise,
    input  logic              bit_fall,
    input  mdio_state_e       state,
    input  logic              is_read,
    input  logic              reg_hit,
    input  logic [DATA_W-1:0] reg_rdata,
    output logic              mdio_oe,
    output logic              mdio_out
);
    logic [DATA_W-1:0] rd_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_sh    <= '0;
            mdio_oe  <= 1'b0;
            mdio_out <= 1'b0;
        end else begin
            if (bit_rise && is_read) begin
                if (state == ST_TA2)
                    rd_sh <= reg_hit ? reg_rdata : '1;
                else if (state == ST_DATA)
                    rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
            end
            if (bit_fall) begin
                if (is_read && state == ST_TA2) begin
                    mdio_oe  <= 1'b1;
                    mdio_out <= 1'b0;
                end else if (is_read && state == ST_DATA) begin
                    mdio_oe  <= 1'b1;
                    mdio_out <= rd_sh[DATA_W-1];
                end else begin
                    mdio_oe  <= 1'b0;
                    mdio_out <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/mdio_target.sv
module mdio_target
    import mdio_target_pkg::*;
#(
    parameter int PHY_AW      = 5,
    parameter int REG_AW      = 5,
    parameter int DATA_W      = 16,
    parameter int PRE_MIN     = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mdc,
    input  logic              mdio_in,
    output logic              mdio_oe,
    output logic              mdio_out,
    input  logic [PHY_AW-1:0] phy_addr_strap,
    output logic [REG_AW-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [DATA_W-1:0] reg_rdata,
    input  logic              reg_hit
);
    logic [PHY_AW-1:0] phy_addr_q;
    mdc_evt_t          evt;
    mdio_state_e       frame_state;
    logic              frame_rd;
    logic              mdc_rise;

    always_ff @(posedge clk) begin
        if (rst) phy_addr_q <= phy_addr_strap;
    end

    assign mdc_rise = evt.rise;

    mdio_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .mdc     (mdc),
        .mdio_in (mdio_in),
        .evt     (evt)
    );

    mdio_frame_fsm #(
        .PHY_AW (PHY_AW),
        .REG_AW (REG_AW),
        .DATA_W (DATA_W),
        .PRE_MIN(PRE_MIN)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .bit_rise (evt.rise),
        .bit_val  (evt.bit_val),
        .own_addr (phy_addr_q),
        .reg_hit  (reg_hit),
        .state    (frame_state),
        .is_read  (frame_rd),
        .reg_addr (reg_addr),
        .reg_we   (reg_we),
        .reg_wdata(reg_wdata)
    );

    mdio_read_driver #(.DATA_W(DATA_W)) u_drv (
        .clk      (clk),
        .rst      (rst),
        .bit_rise (evt.rise),
        .bit_fall (evt.fall),
        .state    (frame_state),
        .is_read  (frame_rd),
        .reg_hit  (reg_hit),
        .reg_rdata(reg_rdata),
        .mdio_oe  (mdio_oe),
        .mdio_out (mdio_out)
    );
endmodule

// File: rtl/mdio_target_chk.sv
module mdio_target_chk
    import mdio_target_pkg::*;
#(
    parameter int PHY_AW = 5
) (
    input logic              clk,
    input logic              rst,
    input mdio_state_e       st,
    input logic              mdio_oe,
    input logic              mdio_out,
    input logic              reg_we,
    input logic              reg_hit,
    input logic              mdc_rise,
    input logic [PHY_AW-1:0] phy_addr_q
);
    a_r8_strobe_single: assert property (@(posedge clk) disable iff (rst)
        reg_we |=> !reg_we);

    a_r9_strobe_needs_hit: assert property (@(posedge clk) disable iff (rst)
        reg_we |-> reg_hit);

    a_r8_strobe_after_rise: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_we) |-> $past(mdc_rise));

    a_r5_drive_opens_low: assert property (@(posedge clk) disable iff (rst)
        $rose(mdio_oe) |-> (st == ST_TA2 && !mdio_out));

    a_r1_addr_hold: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(phy_addr_q));
endmodule

bind mdio_target mdio_target_chk #(.PHY_AW(PHY_AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .st        (frame_state),
    .mdio_oe   (mdio_oe),
    .mdio_out  (mdio_out),
    .reg_we    (reg_we),
    .reg_hit   (reg_hit),
    .mdc_rise  (mdc_rise),
    .phy_addr_q(phy_addr_q)
);

// File: tb/mdio_target_bench.sv
module mdio_target_bench;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic        mdc = 1'b1;
    logic        st_oe = 1'b0;
    logic        st_val = 1'b1;
    logic [4:0]  strap = 5'd5;
    logic        dut_oe, dut_out, mdio_line;
    logic [4:0]  reg_addr;
    logic [15:0] reg_wdata, reg_rdata;
    logic        reg_we, reg_hit;
    logic [15:0] bank [32];
    int          checks = 0;
    int          errors = 0;
    int          we_cnt = 0;

    assign mdio_line = dut_oe ? dut_out : (st_oe ? st_val : 1'b1);

    function automatic logic implemented(input logic [4:0] a);
        return (a < 5'd8) || (a >= 5'd16 && a < 5'd20);
    endfunction

    assign reg_hit   = implemented(reg_addr);
    assign reg_rdata = bank[reg_addr];

    always @(posedge clk) begin
        if (reg_we) begin
            bank[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
    end

    mdio_target u_mdio_target (
        .clk(clk), .rst(rst), .mdc(mdc), .mdio_in(mdio_line),
        .mdio_oe(dut_oe), .mdio_out(dut_out), .phy_addr_strap(strap),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .reg_hit(reg_hit)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic clk_bit(input logic drv, input logic val, output logic line, output logic oe);
        @(negedge clk);
        mdc = 1'b0; st_oe = drv; st_val = val;
        repeat (3) @(negedge clk);
        line = mdio_line; oe = dut_oe;
        @(negedge clk);
        mdc = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                         input logic [4:0] ra, input logic [1:0] ta, input logic ta_drv,
                         input logic [15:0] wd, input logic d_drv,
                         output logic [15:0] rd, output logic [1:0] ta_oe,
                         output logic [1:0] ta_line, output int oe_cnt);
        logic l, o;
        logic [13:0] hdr;
        oe_cnt = 0;
        for (int i = 0; i < pre; i++) clk_bit(1'b1, 1'b1, l, o);
        hdr = {2'b01, op, phy, ra};
        for (int i = 13; i >= 0; i--) begin
            clk_bit(1'b1, hdr[i], l, o);
            oe_cnt += int'(o);
        end
        clk_bit(ta_drv, ta[1], ta_line[1], ta_oe[1]);
        clk_bit(ta_drv, ta[0], ta_line[0], ta_oe[0]);
        for (int i = 15; i >= 0; i--) begin
            clk_bit(d_drv, wd[i], rd[i], o);
            oe_cnt += int'(o);
        end
        st_oe = 1'b0;
    endtask

    task automatic do_write(input int pre, input logic [1:0] op, input logic [4:0] phy,
                            input logic [4:0] ra, input logic [1:0] ta,
                            input logic [15:0] wd, output int oe_cnt);
        logic [15:0] rd;
        logic [1:0]  ta_oe, ta_line;
        frame(pre, op, phy, ra, ta, 1'b1, wd, 1'b1, rd, ta_oe, ta_line, oe_cnt);
        oe_cnt += int'(ta_oe[1]) + int'(ta_oe[0]);
        repeat (2) @(negedge clk);
    endtask

    task automatic do_read(input logic [4:0] phy, input logic [4:0] ra,
                           output logic [15:0] rd, output logic [1:0] ta_oe,
                           output logic [1:0] ta_line, output int oe_cnt);
        frame(32, 2'b10, phy, ra, 2'b11, 1'b0, 16'h0, 1'b0, rd, ta_oe, ta_line, oe_cnt);
    endtask

    task automatic t_reset();
        check("R11 oe after reset", dut_oe, 1'b0);
        check("R8 no strobe after reset", reg_we, 1'b0);
    endtask

    task automatic t_write_read();
        int w0, oc;
        logic [15:0] rd;
        logic [1:0] to, tl;
        logic l, o;
        w0 = we_cnt;
        do_write(32, 2'b01, 5'd5, 5'd3, 2'b10, 16'h1234, oc);
        check("R8 one strobe", we_cnt, w0 + 1);
        check("R8 data stored", bank[3], 16'h1234);
        check("R11 no drive in write", oc, 0);
        do_read(5'd5, 5'd3, rd, to, tl, oc);
        check("R6 read data msb first", rd, 16'h1234);
        check("R5 ta enable pattern", to, 2'b01);
        check("R5 ta second bit low", tl[0], 1'b0);
        check("R6 sixteen driven bits", oc, 16);
        clk_bit(1'b0, 1'b1, l, o);
        check("R11 released after read", o, 1'b0);
        do_read(5'd5, 5'd17, rd, to, tl, oc);
        check("R6 preset register", rd, 16'hA511);
    endtask

    task automatic t_unimpl();
        int w0, oc;
        logic [15:0] rd;
        logic [1:0] to, tl;
        do_read(5'd5, 5'd10, rd, to, tl, oc);
        check("R7 missing reg reads ones", rd, 16'hFFFF);
        w0 = we_cnt;
        do_write(32, 2'b01, 5'd5, 5'd10, 2'b10, 16'h0000, oc);
        check("R9 no strobe to missing reg", we_cnt, w0);
        do_write(32, 2'b01, 5'd5, 5'd24, 2'b10, 16'h0000, oc);
        check("R9 no strobe upper missing", we_cnt, w0);
    endtask

    task automatic t_opcode();
        int w0, oc;
        w0 = we_cnt;
        do_write(32, 2'b00, 5'd5, 5'd2, 2'b10, 16'h5555, oc);
        check("R3 op 00 no strobe", we_cnt, w0);
        check("R3 op 00 no drive", oc, 0);
        do_write(32, 2'b11, 5'd5, 5'd2, 2'b10, 16'h5555, oc);
        check("R3 op 11 no strobe", we_cnt, w0);
        check("R3 op 11 no drive", oc, 0);
        check("R3 reg untouched", bank[2], 16'hA502);
    endtask

    task automatic t_mismatch();
        int w0, oc;
        logic [15:0] rd;
        logic [1:0] to, tl;
        do_read(5'd7, 5'd3, rd, to, tl, oc);
        check("R4 other phy no data drive", oc, 0);
        check("R4 other phy no ta drive", to, 2'b00);
        w0 = we_cnt;
        do_write(32, 2'b01, 5'd4, 5'd3, 2'b10, 16'hDEAD, oc);
        check("R4 other phy no strobe", we_cnt, w0);
    endtask

    task automatic t_short_preamble();
        int w0, oc;
        logic l, o;
        logic [15:0] rd;
        logic [1:0] to, tl;
        clk_bit(1'b1, 1'b0, l, o);
        w0 = we_cnt;
        do_write(31, 2'b01, 5'd5, 5'd4, 2'b10, 16'hBEEF, oc);
        check("R2 31 ones ignored", we_cnt, w0);
        do_read(5'd5, 5'd4, rd, to, tl, oc);
        check("R2 reg unchanged", rd, 16'hA504);
    endtask

    task automatic t_bad_ta();
        int w0, oc;
        w0 = we_cnt;
        do_write(32, 2'b01, 5'd5, 5'd5, 2'b11, 16'h7777, oc);
        check("R12 ta 11 dropped", we_cnt, w0);
        do_write(32, 2'b01, 5'd5, 5'd5, 2'b00, 16'h7777, oc);
        check("R12 ta 00 dropped", we_cnt, w0);
        check("R12 reg untouched", bank[5], 16'hA505);
    endtask

    task automatic t_back_to_back();
        int oc;
        logic [15:0] rd;
        logic [1:0] to, tl;
        logic [15:0] rd2;
        logic [1:0] to2, tl2;
        int oc2;
        frame(32, 2'b01, 5'd5, 5'd6, 2'b10, 1'b1, 16'h0F0F, 1'b1, rd, to, tl, oc);
        do_read(5'd5, 5'd6, rd, to, tl, oc);
        check("R10 read right after write", rd, 16'h0F0F);
        do_read(5'd5, 5'd16, rd2, to2, tl2, oc2);
        check("R10 read right after read", rd2, 16'hA510);
    endtask

    task automatic t_strap();
        int oc;
        logic [15:0] rd;
        logic [1:0] to, tl;
        strap = 5'd9;
        repeat (4) @(negedge clk);
        do_read(5'd9, 5'd3, rd, to, tl, oc);
        check("R1 new strap ignored", oc, 0);
        do_read(5'd5, 5'd3, rd, to, tl, oc);
        check("R1 captured addr answers", rd, 16'h1234);
    endtask

    initial begin
        for (int i = 0; i < 32; i++) bank[i] = 16'hA500 + 16'(i);
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_write_read();
        t_unimpl();
        t_opcode();
        t_mismatch();
        t_short_preamble();
        t_bad_ta();
        t_back_to_back();
        t_strap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule